// File: doc/BRIEF.md
# Privilege Mode Guard with Address Window and Watchdog Timer

This block sits beside a small processor core and enforces two execution privileges. A single mode bit records whether the core is running privileged system code or an unprivileged application. While the core is unprivileged, every memory access it issues is compared against a window set by a start register and a size register. An access outside the window, or any attempt to run a privileged operation, produces a one-cycle fault pulse with a cause code. The same fault also forces the core back into privileged mode so that the system software regains control.

A countdown timer stops an application from keeping the core indefinitely. Privileged code loads the timer. The timer then counts down once per clock. When it reaches zero it raises a pending interrupt that stays up until the timer is reloaded, and the interrupt also returns the core to privileged mode. Privileged code leaves for an application only through an explicit return request.

Top module: `priv_guard`

## Requirements
- R1: After reset the mode output is 0 (kernel), and the fault and timer interrupt outputs are low.
- R2: A return request in kernel mode sets the mode output to 1 (user) on the next cycle. Mode encoding: 0 = kernel, 1 = user.
- R3: In user mode a valid access with base <= address < base + limit raises no fault.
- R4: In user mode a valid access outside that window raises the fault output for exactly one cycle, in the cycle after the access, with cause code 0.
- R5: In kernel mode no access raises a fault, whatever its address.
- R6: In user mode a register write (select 0 = base, 1 = limit, 2 = timer) or an asserted privileged-operation flag raises a fault with cause 1 in the next cycle. A blocked register write leaves the target register unchanged.
- R7: Every fault switches the mode to kernel in the same cycle that the fault output goes high.
- R8: Once loaded with N in kernel mode, the timer raises its interrupt exactly N cycles after the load edge.
- R9: The timer interrupt stays high, with the counter held at zero, until a kernel-mode timer write clears it. A reload value of 0 clears the interrupt and starts no new count.
- R10: Timer expiry switches the mode to kernel in the same cycle that the interrupt rises.
- R11: When a return request meets a fault or a timer expiry in the same cycle, the mode remains or becomes kernel.
- R12: The window end is computed one bit wider than the address, so a window that ends exactly at the top of the address space does not wrap around.
- R13: When a range violation and a privileged violation occur in the same cycle, the cause code is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Memory access strobe |
| acc_addr_i | input | ADDR_W | Physical address of the access |
| reg_we_i | input | 1 | Protection register write strobe |
| reg_sel_i | input | 2 | Register select: 0 base, 1 limit, 2 timer, 3 unused |
| reg_wdata_i | input | ADDR_W | Write data (timer uses the low TMR_W bits) |
| priv_op_i | input | 1 | Core is executing a privileged operation |
| ret_user_i | input | 1 | Request to return to user mode |
| fault_o | output | 1 | One-cycle protection fault pulse |
| fault_cause_o | output | 1 | Fault cause: 0 range, 1 privilege |
| timer_irq_o | output | 1 | Pending timer interrupt |
| mode_o | output | 1 | Current mode: 0 kernel, 1 user |

## Verification
The properties assume that every input is a clean binary value sampled at the rising edge. They also assume that the return request is the only source of a rise in the mode bit, so each rise of the mode output must trace back to a return request one cycle earlier. The bench changes inputs only on the falling edge and keeps each strobe high for exactly one cycle. It leaves user mode only through a fault or a timer expiry, so every transition between modes stays within the sequences that the properties describe.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;
  typedef enum logic {
    MODE_KERNEL = 1'b0,
    MODE_USER   = 1'b1
  } mode_e;

  typedef enum logic {
    CAUSE_RANGE = 1'b0,
    CAUSE_PRIV  = 1'b1
  } cause_e;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_TIMER = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;
endpackage

// File: rtl/pg_window.sv
module pg_window #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              inside_o
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] end_x;
  logic          above_base;
  logic          below_end;

  always_comb begin
    end_x      = {1'b0, base_i} + {1'b0, limit_i};
    above_base = (addr_i >= base_i);
    below_end  = ({1'b0, addr_i} < end_x);
    inside_o   = above_base && below_end;
  end
endmodule

// File: rtl/pg_countdown.sv
module pg_countdown #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             expire_o,
  output logic             irq_o
);
  localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0] ZERO = '0;

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             cnt_en;

  always_comb begin
    expire_o = !load_i && (cnt_q == ONE);
    cnt_en   = load_i || (cnt_q != ZERO);
    cnt_d    = load_i ? load_val_i : cnt_q - ONE;
    if (load_i)        irq_d = 1'b0;
    else if (expire_o) irq_d = 1'b1;
    else               irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pg_mode_ctl.sv
module pg_mode_ctl
  import priv_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fault_det_i,
  input  cause_e cause_i,
  input  logic   expire_i,
  input  logic   ret_i,
  output mode_e  mode_o,
  output logic   fault_o,
  output cause_e cause_o
);
  mode_e  mode_q, mode_d;
  logic   fault_q;
  cause_e cause_q;

  always_comb begin
    mode_d = mode_q;
    if (fault_det_i || expire_i)                mode_d = MODE_KERNEL;
    else if (ret_i && mode_q == MODE_KERNEL)    mode_d = MODE_USER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_KERNEL;
      fault_q <= 1'b0;
      cause_q <= CAUSE_RANGE;
    end else begin
      mode_q  <= mode_d;
      fault_q <= fault_det_i;
      if (fault_det_i) cause_q <= cause_i;
    end
  end

  assign mode_o  = mode_q;
  assign fault_o = fault_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/priv_guard.sv
module priv_guard
  import priv_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              priv_op_i,
  input  logic              ret_user_i,
  output logic              fault_o,
  output logic              fault_cause_o,
  output logic              timer_irq_o,
  output logic              mode_o
);
  mode_e             mode;
  cause_e            cause_d, cause_q;
  logic [ADDR_W-1:0] base_q, limit_q;
  logic              in_window;
  logic              is_kernel, range_viol, priv_viol, fault_det;
  logic              wr_ok, base_en, limit_en, tmr_load;
  logic              expire;

  always_comb begin
    is_kernel  = (mode == MODE_KERNEL);
    wr_ok      = reg_we_i && is_kernel;
    base_en    = wr_ok && (sel_e'(reg_sel_i) == SEL_BASE);
    limit_en   = wr_ok && (sel_e'(reg_sel_i) == SEL_LIMIT);
    tmr_load   = wr_ok && (sel_e'(reg_sel_i) == SEL_TIMER);
    range_viol = !is_kernel && acc_valid_i && !in_window;
    priv_viol  = !is_kernel && (reg_we_i || priv_op_i);
    fault_det  = range_viol || priv_viol;
    cause_d    = priv_viol ? CAUSE_PRIV : CAUSE_RANGE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (base_en)  base_q  <= reg_wdata_i;
      if (limit_en) limit_q <= reg_wdata_i;
    end
  end

  pg_window #(.ADDR_W(ADDR_W)) u_window (
    .base_i   (base_q),
    .limit_i  (limit_q),
    .addr_i   (acc_addr_i),
    .inside_o (in_window)
  );

  pg_countdown #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (reg_wdata_i[TMR_W-1:0]),
    .expire_o   (expire),
    .irq_o      (timer_irq_o)
  );

  pg_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_det_i (fault_det),
    .cause_i     (cause_d),
    .expire_i    (expire),
    .ret_i       (ret_user_i),
    .mode_o      (mode),
    .fault_o     (fault_o),
    .cause_o     (cause_q)
  );

  assign mode_o        = mode;
  assign fault_cause_o = cause_q;
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic              priv_op_i,
  input logic              ret_user_i,
  input logic              fault_o,
  input logic              fault_cause_o,
  input logic              timer_irq_o,
  input logic              mode_o
);
  logic unused_in;
  assign unused_in = acc_valid_i ^ (^acc_addr_i) ^ priv_op_i;

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o); // R4

  AST_KERNEL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 1'b0) |=> !fault_o); // R5

  AST_USER_WRITE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 1'b1 && reg_we_i) |=> (fault_o && fault_cause_o)); // R6

  AST_FAULT_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (mode_o == 1'b0)); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq_o && !(mode_o == 1'b0 && reg_we_i && reg_sel_i == 2'd2)) |=> timer_irq_o); // R9

  AST_IRQ_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_irq_o) |-> (mode_o == 1'b0)); // R10

  AST_RET_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 1'b0 && ret_user_i) |=> (mode_o == 1'b1 || $rose(timer_irq_o))); // R11

  AST_RISE_BY_RET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o) |-> $past(ret_user_i)); // R2

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_o) |-> (fault_o || $rose(timer_irq_o))); // R7
endmodule

bind priv_guard pg_checker #(.ADDR_W(ADDR_W)) u_pg_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid_i   (acc_valid_i),
  .acc_addr_i    (acc_addr_i),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .priv_op_i     (priv_op_i),
  .ret_user_i    (ret_user_i),
  .fault_o       (fault_o),
  .fault_cause_o (fault_cause_o),
  .timer_irq_o   (timer_irq_o),
  .mode_o        (mode_o)
);

// File: tb/priv_guard_test.sv
`timescale 1ns/1ps
module priv_guard_test;
  localparam int AW = 16;
  localparam int TW = 12;

  logic          clk;
  logic          rst_n;
  logic          acc_valid_i;
  logic [AW-1:0] acc_addr_i;
  logic          reg_we_i;
  logic [1:0]    reg_sel_i;
  logic [AW-1:0] reg_wdata_i;
  logic          priv_op_i;
  logic          ret_user_i;
  logic          fault_o;
  logic          fault_cause_o;
  logic          timer_irq_o;
  logic          mode_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 0;

  priv_guard #(.ADDR_W(AW), .TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .priv_op_i(priv_op_i), .ret_user_i(ret_user_i), .fault_o(fault_o),
    .fault_cause_o(fault_cause_o), .timer_irq_o(timer_irq_o), .mode_o(mode_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic kwrite(input logic [1:0] sel, input logic [AW-1:0] val);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = val;
    step();
    reg_we_i = 1'b0; reg_sel_i = 2'd3; reg_wdata_i = '0;
  endtask

  task automatic to_user();
    ret_user_i = 1'b1;
    step();
    ret_user_i = 1'b0;
  endtask

  task automatic to_kernel();
    priv_op_i = 1'b1;
    step();
    priv_op_i = 1'b0;
  endtask

  task automatic access(input logic [AW-1:0] a);
    acc_valid_i = 1'b1; acc_addr_i = a;
    step();
    acc_valid_i = 1'b0; acc_addr_i = '0;
  endtask

  task automatic t_reset();
    check("R1", "mode after reset", mode_o, 0);
    check("R1", "fault after reset", fault_o, 0);
    check("R1", "irq after reset", timer_irq_o, 0);
  endtask

  task automatic t_window();
    kwrite(2'd0, 16'h1000);
    kwrite(2'd1, 16'h0100);
    to_user();
    check("R2", "mode after return", mode_o, 1);
    access(16'h1000);
    check("R3", "fault at base", fault_o, 0);
    access(16'h10FF);
    check("R3", "fault at last legal", fault_o, 0);
    check("R3", "mode stays user", mode_o, 1);
    access(16'h1100);
    check("R4", "fault at window end", fault_o, 1);
    check("R4", "cause range", fault_cause_o, 0);
    check("R7", "mode after fault", mode_o, 0);
    step();
    check("R4", "fault one cycle only", fault_o, 0);
    to_user();
    access(16'h0FFF);
    check("R4", "fault below base", fault_o, 1);
    check("R4", "cause below base", fault_cause_o, 0);
    step();
  endtask

  task automatic t_kernel();
    access(16'h0000);
    check("R5", "kernel fault low addr", fault_o, 0);
    access(16'hFFFF);
    check("R5", "kernel fault high addr", fault_o, 0);
    check("R5", "kernel mode kept", mode_o, 0);
  endtask

  task automatic t_priv();
    to_user();
    reg_we_i = 1'b1; reg_sel_i = 2'd0; reg_wdata_i = 16'h2000;
    step();
    reg_we_i = 1'b0; reg_sel_i = 2'd3; reg_wdata_i = '0;
    check("R6", "fault on user write", fault_o, 1);
    check("R6", "cause on user write", fault_cause_o, 1);
    check("R7", "kernel after user write", mode_o, 0);
    to_user();
    access(16'h1000);
    check("R6", "base unchanged by blocked write", fault_o, 0);
    to_kernel();
    check("R6", "fault on priv op", fault_o, 1);
    check("R6", "cause on priv op", fault_cause_o, 1);
    check("R7", "kernel after priv op", mode_o, 0);
    step();
  endtask

  task automatic t_combo();
    to_user();
    acc_valid_i = 1'b1; acc_addr_i = 16'h0000; priv_op_i = 1'b1;
    step();
    acc_valid_i = 1'b0; priv_op_i = 1'b0;
    check("R13", "fault on double violation", fault_o, 1);
    check("R13", "privilege cause wins", fault_cause_o, 1);
    step();
    to_user();
    ret_user_i = 1'b1; priv_op_i = 1'b1;
    step();
    ret_user_i = 1'b0; priv_op_i = 1'b0;
    check("R11", "fault with return stays kernel", mode_o, 0);
    step();
  endtask

  task automatic t_timer();
    kwrite(2'd2, 16'd5);
    to_user();
    step(); step(); step();
    check("R8", "no irq before N cycles", timer_irq_o, 0);
    check("R8", "user mode before expiry", mode_o, 1);
    step();
    check("R8", "irq after N cycles", timer_irq_o, 1);
    check("R10", "kernel on expiry", mode_o, 0);
    step(); step(); step();
    check("R9", "irq held", timer_irq_o, 1);
    kwrite(2'd2, 16'd0);
    check("R9", "reload clears irq", timer_irq_o, 0);
    step(); step();
    check("R9", "zero reload starts nothing", timer_irq_o, 0);
    kwrite(2'd2, 16'd3);
    step(); step();
    ret_user_i = 1'b1;
    step();
    ret_user_i = 1'b0;
    check("R11", "return with expiry stays kernel", mode_o, 0);
    check("R10", "irq on expiry in kernel", timer_irq_o, 1);
    kwrite(2'd2, 16'd4);
    to_user();
    reg_we_i = 1'b1; reg_sel_i = 2'd2; reg_wdata_i = 16'd100;
    step();
    reg_we_i = 1'b0; reg_sel_i = 2'd3; reg_wdata_i = '0;
    check("R6", "fault on user timer write", fault_o, 1);
    step(); step();
    check("R6", "timer not reloaded by user", timer_irq_o, 1);
    kwrite(2'd2, 16'd0);
  endtask

  task automatic t_top();
    kwrite(2'd0, 16'hFFF0);
    kwrite(2'd1, 16'h0010);
    to_user();
    access(16'hFFF0);
    check("R12", "fault at top window base", fault_o, 0);
    access(16'hFFFF);
    check("R12", "fault at top address", fault_o, 0);
    access(16'h0000);
    check("R12", "fault at address zero", fault_o, 1);
    step();
  endtask

  initial begin
    rst_n = 1'b0;
    acc_valid_i = 1'b0; acc_addr_i = '0;
    reg_we_i = 1'b0; reg_sel_i = 2'd3; reg_wdata_i = '0;
    priv_op_i = 1'b0; ret_user_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_kernel();
    t_priv();
    t_combo();
    t_timer();
    t_top();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule